// File: doc/BRIEF.md
# Serial Controller Status and Interrupt Flag Block

This block holds the event and error flags of a FIFO-based serial controller and drives its interrupt line. The FIFOs and the serial shifter sit outside the block. They report one-cycle event pulses and two live FIFO level signals on its inputs. Software sees four registers through a simple write port and a combinational read port.

The operational status register holds four sticky event flags and shows two live FIFO level bits. The error flag register holds three sticky error flags. An error can be recorded only while its bit in the error enable register is set. Software clears any sticky flag by writing 1 to its bit.

A mask register can suppress the two service-request flags from the interrupt line. The mask takes effect only while the controller runs in DMA mode. In FIFO mode it is ignored. A build parameter can remove the mask register altogether.

There are no states or transitions: each flag bit is a two-valued latch, set by its event and cleared by a write of 1.

Top module: `opflag_regs`

## Requirements
- R1: After reset all sticky flags, the mask register and the error enable register read 0, and `irq` and `xfer_done` are 0.
- R2: Operational register (address 0) holds sticky flags that are set by a pulse on the matching `op_ev` bit and hold until cleared. The bit positions are: bit 0 input service, bit 1 output service, bit 2 max-input-done, bit 3 max-output-done.
- R3: A write to address 0 clears exactly those sticky bits [3:0] whose data bit is 1. A write to address 2 clears exactly those error bits [2:0] whose data bit is 1. Bits written 0 keep their value.
- R4: Address 0 bit 4 shows `fifo_live[0]` (output FIFO full) and bit 5 shows `fifo_live[1]` (input FIFO not empty), live in the same cycle. Writing to these bits has no effect.
- R5: Error register (address 2) bit i (0 input underrun, 1 output overrun, 2 output underrun) is set by `err_ev[i]` only if enable bit i in address 3 was 1 before that clock edge. Address 3 is read/write in bits [2:0].
- R6: `irq` is 1 exactly when some error flag is set, or some operational sticky flag is set and not masked. The mask register (address 1, bits [1:0]) masks only the input service (bit 0) and output service (bit 1) flags.
- R7: While `dma_mode` is 0, the mask register has no effect on `irq`.
- R8: `xfer_done` is 1 exactly when the max-input-done flag or any error flag is set.
- R9: If an event and a write-1 clear hit the same flag in the same cycle, the flag is set after that edge.
- R10: With `HAS_OP_MASK` = 0, address 1 reads 0, writes to it are ignored, and service flags always raise `irq`.
- R11: Reads of addresses 4 to 7 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| dma_mode | input | 1 | 1 = DMA transfer mode, 0 = FIFO mode |
| op_ev | input | 4 | Operational event pulses (bit order as R2) |
| fifo_live | input | 2 | Live FIFO levels: [0] output full, [1] input not empty |
| err_ev | input | 3 | Error event pulses (bit order as R5) |
| irq | output | 1 | Interrupt request |
| xfer_done | output | 1 | Transfer completion indication |

## Verification
The hardest situations to reach are collisions in a single cycle. In one case an event pulse and a write-1 clear hit the same flag. In another, an error event arrives in the same cycle that software writes its enable bit. The stimulus lines up these pulses with the write strobe on purpose, so the outcome depends on the ordering rule and on the enable value that was in effect before the edge. The mask is also exercised in both transfer modes while the same service flag is held. A second instance built without the mask register receives the same writes, so that the ignored-write case can be seen at its read port.

// File: rtl/opflag_pkg.sv
package opflag_pkg;
    localparam int OP_W   = 4;
    localparam int SVC_W  = 2;
    localparam int ERR_W  = 3;
    localparam int LIVE_W = 2;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_OPSTAT  = 3'd0,
        REG_OPMASK  = 3'd1,
        REG_ERRFLAG = 3'd2,
        REG_ERREN   = 3'd3
    } reg_addr_e;

    localparam int BIT_MAX_IN_DONE = 2;
endpackage

// File: rtl/opflag_sticky_bank.sv
module opflag_sticky_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[g] <= 1'b0;
            else if (set_i[g])
                q_o[g] <= 1'b1;
            else if (clr_i[g])
                q_o[g] <= 1'b0;
        end

        // R9: a set in the same cycle as a clear leaves the flag set
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> q_o[g]);
        // R2: a set flag with no clear stays set
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[g] && !clr_i[g]) |=> q_o[g]);
        // R3: a clear with no set empties the flag
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !q_o[g]);
    end
endmodule

// File: rtl/opflag_irq_combine.sv
module opflag_irq_combine #(
    parameter int OPW  = 4,
    parameter int SVCW = 2,
    parameter int ERRW = 3,
    parameter int DONE_BIT = 2
) (
    input  logic [OPW-1:0]  op_q,
    input  logic [SVCW-1:0] mask_q,
    input  logic            dma_mode,
    input  logic [ERRW-1:0] err_q,
    output logic            irq_o,
    output logic            done_o
);
    localparam int PAD_W = OPW - SVCW;

    logic [OPW-1:0] mask_eff;
    logic [OPW-1:0] op_visible;

    always_comb begin
        mask_eff   = dma_mode ? {{PAD_W{1'b0}}, mask_q} : '0;
        op_visible = op_q & ~mask_eff;
        irq_o      = (|err_q) | (|op_visible);
        done_o     = op_q[DONE_BIT] | (|err_q);
    end
endmodule

// File: rtl/opflag_regs.sv
module opflag_regs
    import opflag_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter bit HAS_OP_MASK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dma_mode,
    input  logic [3:0]        op_ev,
    input  logic [1:0]        fifo_live,
    input  logic [2:0]        err_ev,
    output logic              irq,
    output logic              xfer_done
);
    localparam int USED_W = OP_W + LIVE_W;

    logic [OP_W-1:0]  op_q;
    logic [OP_W-1:0]  op_clr;
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_clr;
    logic [ERR_W-1:0] err_set;
    logic [ERR_W-1:0] err_en_q;
    logic [SVC_W-1:0] mask_q;
    logic             unused_wbits;

    assign unused_wbits = ^wr_data[DATA_W-1:USED_W];

    always_comb begin
        op_clr  = (wr_en && addr == REG_OPSTAT)  ? wr_data[OP_W-1:0]  : '0;
        err_clr = (wr_en && addr == REG_ERRFLAG) ? wr_data[ERR_W-1:0] : '0;
        err_set = err_ev & err_en_q;
    end

    opflag_sticky_bank #(.W(OP_W)) u_op_bank (
        .clk(clk), .rst_n(rst_n), .set_i(op_ev), .clr_i(op_clr), .q_o(op_q)
    );

    opflag_sticky_bank #(.W(ERR_W)) u_err_bank (
        .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .q_o(err_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            err_en_q <= '0;
        else if (wr_en && addr == REG_ERREN)
            err_en_q <= wr_data[ERR_W-1:0];
    end

    if (HAS_OP_MASK) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q <= '0;
            else if (wr_en && addr == REG_OPMASK)
                mask_q <= wr_data[SVC_W-1:0];
        end
    end else begin : g_nomask
        assign mask_q = '0;
        // R10: without the mask register its address reads as zero
        p_nomask_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == REG_OPMASK) |-> (rd_data == '0));
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            REG_OPSTAT:  rd_data[USED_W-1:0] = {fifo_live, op_q};
            REG_OPMASK:  rd_data[SVC_W-1:0]  = mask_q;
            REG_ERRFLAG: rd_data[ERR_W-1:0]  = err_q;
            REG_ERREN:   rd_data[ERR_W-1:0]  = err_en_q;
            default:     rd_data = '0;
        endcase
    end

    opflag_irq_combine #(
        .OPW(OP_W), .SVCW(SVC_W), .ERRW(ERR_W), .DONE_BIT(BIT_MAX_IN_DONE)
    ) u_irq (
        .op_q(op_q), .mask_q(mask_q), .dma_mode(dma_mode), .err_q(err_q),
        .irq_o(irq), .done_o(xfer_done)
    );

    // R5: an error flag only rises when enabled and pulsed before the edge
    p_err_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q & ~$past(err_q) & ~$past(err_ev & err_en_q)) == '0));
    // R8: completion always comes with an interrupt request
    p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> irq);
    // R7: in FIFO mode any sticky operational flag raises the interrupt
    p_fifo_nomask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_mode && (op_q != '0)) |-> irq);
    // R11: unmapped addresses read zero
    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[2]) |-> (rd_data == '0));
endmodule

// File: tb/opflag_regs_test.sv
module opflag_regs_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic        dma_mode = 1'b0;
    logic [3:0]  op_ev = '0;
    logic [1:0]  fifo_live = '0;
    logic [2:0]  err_ev = '0;
    logic [31:0] rd_data, rd_nm;
    logic        irq, xfer_done, irq_nm, done_nm;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [3:0] op_m;
    logic [2:0] err_m, en_m;
    logic [1:0] mask_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    opflag_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .dma_mode(dma_mode), .op_ev(op_ev),
        .fifo_live(fifo_live), .err_ev(err_ev), .irq(irq), .xfer_done(xfer_done)
    );

    opflag_regs #(.HAS_OP_MASK(1'b0)) uut_nm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_nm), .dma_mode(dma_mode), .op_ev(op_ev),
        .fifo_live(fifo_live), .err_ev(err_ev), .irq(irq_nm), .xfer_done(done_nm)
    );

    function automatic logic [31:0] exp_rd(input logic has_mask);
        case (addr)
            3'd0: return {26'b0, fifo_live, op_m};
            3'd1: return has_mask ? {30'b0, mask_m} : 32'b0;
            3'd2: return {29'b0, err_m};
            3'd3: return {29'b0, en_m};
            default: return 32'b0;
        endcase
    endfunction

    function automatic logic exp_irq(input logic has_mask);
        logic [3:0] me;
        me = (dma_mode && has_mask) ? {2'b0, mask_m} : 4'b0;
        return (|err_m) | (|(op_m & ~me));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, rd_data, exp_rd(1'b1), "rd_data");
        chk(tag, {31'b0, irq}, {31'b0, exp_irq(1'b1)}, "irq");
        chk(tag, {31'b0, xfer_done}, {31'b0, op_m[2] | (|err_m)}, "xfer_done");
        chk(tag, rd_nm, exp_rd(1'b0), "rd_data nomask");
        chk(tag, {31'b0, irq_nm}, {31'b0, exp_irq(1'b0)}, "irq nomask");
    endtask

    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d,
                       input logic dm, input logic [3:0] ev, input logic [1:0] lv,
                       input logic [2:0] er, input string tag);
        wr_en = w; addr = a; wr_data = d; dma_mode = dm;
        op_ev = ev; fifo_live = lv; err_ev = er;
        #1;
        compare(tag);
        @(posedge clk);
        op_m  = (op_m & ~((w && a == 3'd0) ? d[3:0] : 4'b0)) | ev;
        err_m = (err_m & ~((w && a == 3'd2) ? d[2:0] : 3'b0)) | (er & en_m);
        if (w && a == 3'd1) mask_m = d[1:0];
        if (w && a == 3'd3) en_m = d[2:0];
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input logic dm, input string tag);
        cyc(1'b0, a, 32'h0, dm, 4'h0, 2'b00, 3'b000, tag);
    endtask

    initial begin
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        op_m = '0; err_m = '0; en_m = '0; mask_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state on every register
        for (int i = 0; i < 4; i++) rd(3'(i), 1'b0, "R1");
        rd(3'd1, 1'b1, "R1");
        // R2 sticky operational events
        cyc(1'b0, 3'd0, 0, 1'b0, 4'b0001, 2'b00, 3'b000, "R2");
        rd(3'd0, 1'b0, "R2");
        rd(3'd0, 1'b0, "R2");
        cyc(1'b0, 3'd0, 0, 1'b0, 4'b1100, 2'b00, 3'b000, "R2");
        rd(3'd0, 1'b0, "R8");
        // R3 selective write-1 clear
        cyc(1'b1, 3'd0, 32'h4, 1'b0, 4'b0000, 2'b00, 3'b000, "R3");
        rd(3'd0, 1'b0, "R3");
        cyc(1'b1, 3'd0, 32'hFF, 1'b0, 4'b0000, 2'b00, 3'b000, "R3");
        rd(3'd0, 1'b0, "R3");
        // R4 live FIFO bits
        cyc(1'b0, 3'd0, 0, 1'b0, 4'b0000, 2'b11, 3'b000, "R4");
        cyc(1'b0, 3'd0, 0, 1'b0, 4'b0000, 2'b01, 3'b000, "R4");
        cyc(1'b1, 3'd0, 32'h30, 1'b0, 4'b0000, 2'b10, 3'b000, "R4");
        rd(3'd0, 1'b0, "R4");
        // R5 error enables
        cyc(1'b0, 3'd2, 0, 1'b0, 4'b0000, 2'b00, 3'b111, "R5");
        rd(3'd2, 1'b0, "R5");
        cyc(1'b1, 3'd3, 32'h2, 1'b0, 4'b0000, 2'b00, 3'b111, "R5");
        rd(3'd2, 1'b0, "R5");
        cyc(1'b0, 3'd2, 0, 1'b0, 4'b0000, 2'b00, 3'b111, "R5");
        rd(3'd2, 1'b0, "R8");
        cyc(1'b1, 3'd3, 32'h7, 1'b0, 4'b0000, 2'b00, 3'b000, "R5");
        cyc(1'b0, 3'd2, 0, 1'b0, 4'b0000, 2'b00, 3'b101, "R5");
        rd(3'd3, 1'b0, "R5");
        cyc(1'b1, 3'd2, 32'h5, 1'b0, 4'b0000, 2'b00, 3'b000, "R3");
        cyc(1'b1, 3'd2, 32'h7, 1'b0, 4'b0000, 2'b00, 3'b000, "R3");
        rd(3'd2, 1'b0, "R8");
        // R6 / R7 / R10 mask behaviour
        cyc(1'b1, 3'd1, 32'h3, 1'b0, 4'b0001, 2'b00, 3'b000, "R10");
        rd(3'd1, 1'b0, "R7");
        rd(3'd1, 1'b1, "R6");
        cyc(1'b0, 3'd1, 0, 1'b1, 4'b0010, 2'b00, 3'b000, "R6");
        rd(3'd1, 1'b1, "R6");
        cyc(1'b1, 3'd1, 32'h1, 1'b1, 4'b0000, 2'b00, 3'b000, "R10");
        rd(3'd0, 1'b1, "R6");
        cyc(1'b1, 3'd0, 32'h2, 1'b1, 4'b0000, 2'b00, 3'b000, "R6");
        rd(3'd0, 1'b1, "R6");
        rd(3'd0, 1'b0, "R7");
        cyc(1'b0, 3'd0, 0, 1'b1, 4'b1000, 2'b00, 3'b000, "R6");
        rd(3'd0, 1'b1, "R6");
        // R9 event beats clear
        cyc(1'b1, 3'd0, 32'hF, 1'b0, 4'b1001, 2'b00, 3'b000, "R9");
        rd(3'd0, 1'b0, "R9");
        cyc(1'b1, 3'd2, 32'h7, 1'b0, 4'b0000, 2'b00, 3'b010, "R9");
        rd(3'd2, 1'b0, "R9");
        // R11 unmapped addresses
        for (int a = 4; a < 8; a++) begin
            cyc(1'b1, 3'(a), 32'hFFFF_FFFF, 1'b1, 4'b0000, 2'b11, 3'b000, "R11");
            rd(3'(a), 1'b1, "R11");
        end
        for (int i = 0; i < 4; i++) rd(3'(i), 1'b1, "R11");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule